// File: doc/BRIEF.md
# Codec Control Register Bank with Write Filtering

This block holds the sixty-four 16-bit control words of an audio codec. Each word sits at an even 7-bit address. A host-side frame decoder issues one write and/or one read per clock. Every write passes a per-address rule before it is stored:

- Some addresses drop the write.
- Some force a fixed bit pattern into part of the word.
- Some replace the whole word with a constant.

A read returns the stored word on the next cycle. The low address bit is not decoded, so an odd address reaches the even word below it. A synchronous reset loads each word from a computed reset table. The two vendor-identification words take parameter constants, the two rate words take BB80h, and every other word takes zero.

Neither request can be stalled. `wr_en` and `rd_en` are accepted in every cycle, so there is no ready signal and no back-pressure. `rd_valid` marks the cycle in which `rdata` carries a result, and the host must take it then.

Top module: `codec_regs`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0 and `rdata` is 0000h. A read of 7Ch returns `VID1`, a read of 7Eh returns `VID2`, reads of 32h and 34h return BB80h, and every other address returns 0000h.
- R2: A write to any address not named in R3 to R7 stores all 16 bits of `wdata` unchanged.
- R3: Writes to 7Ch and 7Eh are discarded and those words keep their contents.
- R4: Writes to 28h are discarded, so that word stays 0000h.
- R5: A write to 26h stores `wdata[15:4]` in bits 15:4 and the value 4'b1110 in bits 3:0.
- R6: A write to 2Ah stores `wdata[15:10]` and `wdata[5:0]` in the same positions and the value 4'b0111 in bits 9:6.
- R7: Any write to 32h or 34h stores BB80h, whatever `wdata` holds.
- R8: Address bit 0 is ignored, so address 2k+1 reads and writes the same word as 2k.
- R9: When `rd_en` is high at a clock edge, `rd_valid` is high after that edge and `rdata` carries the addressed word. When `rd_en` is low, `rd_valid` is low and `rdata` keeps its previous value.
- R10: When a read and a write hit the same word in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, accepted every cycle |
| rd_en | input | 1 | Read request, accepted every cycle |
| addr | input | ADDR_W (7) | Register address shared by the read and the write |
| wdata | input | 16 | Write data before filtering |
| rdata | output | 16 | Read result |
| rd_valid | output | 1 | High in the cycle after an accepted read |

## Verification
Every result is due exactly one clock after its request. A write shows up in any read issued in a later cycle. A read shows the word as it stood before any write issued in the same cycle. The bench drives each request just after a falling edge and compares `rd_valid` and `rdata` at the next falling edge, which falls after the single register stage. It also confirms that `rdata` holds its value in every cycle without a read.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  typedef logic [15:0] word_t;

  typedef enum logic [2:0] {
    RULE_PASS,
    RULE_DROP,
    RULE_LOW_NIB,
    RULE_MID_NIB,
    RULE_FIXED
  } wr_rule_e;

  // word indices (address divided by two)
  localparam int IDX_LOWFIX = 'h26 / 2;
  localparam int IDX_RO_ID  = 'h28 / 2;
  localparam int IDX_MIDFIX = 'h2A / 2;
  localparam int IDX_RATE_A = 'h32 / 2;
  localparam int IDX_RATE_B = 'h34 / 2;
  localparam int IDX_VEND_1 = 'h7C / 2;
  localparam int IDX_VEND_2 = 'h7E / 2;

  localparam word_t RATE_WORD = 16'hBB80;
  localparam logic [3:0] LOW_PAT = 4'b1110;
  localparam logic [3:0] MID_PAT = 4'b0111;

  function automatic wr_rule_e rule_of(input int idx);
    case (idx)
      IDX_VEND_1, IDX_VEND_2, IDX_RO_ID: return RULE_DROP;
      IDX_LOWFIX:                        return RULE_LOW_NIB;
      IDX_MIDFIX:                        return RULE_MID_NIB;
      IDX_RATE_A, IDX_RATE_B:            return RULE_FIXED;
      default:                           return RULE_PASS;
    endcase
  endfunction

  function automatic word_t reset_word(input int idx, input word_t v1, input word_t v2);
    case (idx)
      IDX_VEND_1:             return v1;
      IDX_VEND_2:             return v2;
      IDX_RATE_A, IDX_RATE_B: return RATE_WORD;
      default:                return '0;
    endcase
  endfunction

endpackage

// File: rtl/cregs_write_filter.sv
module cregs_write_filter
  import codec_regs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             req_en,
  input  logic [IDX_W-1:0] req_idx,
  input  word_t            req_data,
  output logic             store_en,
  output word_t            store_word
);

  wr_rule_e rule;

  always_comb begin
    rule       = rule_of(int'(req_idx));
    store_en   = req_en;
    store_word = req_data;
    unique case (rule)
      RULE_DROP:    store_en   = 1'b0;
      RULE_LOW_NIB: store_word = {req_data[15:4], LOW_PAT};
      RULE_MID_NIB: store_word = {req_data[15:10], MID_PAT, req_data[5:0]};
      RULE_FIXED:   store_word = RATE_WORD;
      default:      store_word = req_data;
    endcase
  end

endmodule

// File: rtl/cregs_storage.sv
module cregs_storage
  import codec_regs_pkg::*;
#(
  parameter int    IDX_W = 6,
  parameter word_t VID1  = 16'h4D44,
  parameter word_t VID2  = 16'h4410
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_word,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_word,
  output logic             rd_valid
);

  localparam int NREG = 1 << IDX_W;

  word_t mem [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          mem[g] <= reset_word(g, VID1, VID2);
        else if (wr_en && (int'(wr_idx) == g))
          mem[g] <= wr_word;
      end
    end
  endgenerate

  // read samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_word <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/codec_regs.sv
module codec_regs
  import codec_regs_pkg::*;
#(
  parameter int    ADDR_W = 7,
  parameter word_t VID1   = 16'h4D44,
  parameter word_t VID2   = 16'h4410
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              rd_valid
);

  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             st_en;
  word_t            st_word;

  assign idx = addr[ADDR_W-1:1];

  cregs_write_filter #(.IDX_W(IDX_W)) u_filter (
    .req_en     (wr_en),
    .req_idx    (idx),
    .req_data   (wdata),
    .store_en   (st_en),
    .store_word (st_word)
  );

  cregs_storage #(.IDX_W(IDX_W), .VID1(VID1), .VID2(VID2)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (st_en),
    .wr_idx   (idx),
    .wr_word  (st_word),
    .rd_en    (rd_en),
    .rd_idx   (idx),
    .rd_word  (rdata),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/codec_regs_chk.sv
module codec_regs_chk #(
  parameter int          ADDR_W = 7,
  parameter logic [15:0] VID1   = 16'h4D44,
  parameter logic [15:0] VID2   = 16'h4410
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       rdata,
  input logic              rd_valid
);

  logic [ADDR_W-2:0] ix;
  assign ix = addr[ADDR_W-1:1];

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);  // R9
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));  // R9
  AST_RATE_CONST: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(ix) == 'h19 || int'(ix) == 'h1A)) |=> rdata == 16'hBB80);  // R7
  AST_VENDOR1_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(ix) == 'h3E) |=> rdata == VID1);  // R3
  AST_VENDOR2_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(ix) == 'h3F) |=> rdata == VID2);  // R3
  AST_RO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(ix) == 'h14) |=> rdata == 16'h0000);  // R4

endmodule

bind codec_regs codec_regs_chk #(.ADDR_W(ADDR_W), .VID1(VID1), .VID2(VID2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .rd_valid (rd_valid)
);

// File: tb/tb_codec_regs.sv
module tb_codec_regs;

  localparam logic [15:0] V1 = 16'h4D44;
  localparam logic [15:0] V2 = 16'h4410;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  int model [64];
  logic [15:0] last_rd = 16'h0;

  always #4 clk = ~clk;

  codec_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  function automatic string tag_of(input int a);
    case (a & 'h7E)
      'h7C, 'h7E: return "R3";
      'h28:       return "R4";
      'h26:       return "R5";
      'h2A:       return "R6";
      'h32, 'h34: return "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) model[i] = 0;
    model['h3E] = V1;
    model['h3F] = V2;
    model['h19] = 'hBB80;
    model['h1A] = 'hBB80;
  endtask

  task automatic model_write(input int a, input logic [15:0] d);
    int w;
    w = a / 2;
    case (w * 2)
      'h7C, 'h7E, 'h28: ;
      'h26: model[w] = (d & 'hFFF0) | 'hE;
      'h2A: model[w] = (d & 'hFC3F) | ('h7 << 6);
      'h32, 'h34: model[w] = 'hBB80;
      default: model[w] = d;
    endcase
  endtask

  // one cycle: drive after a falling edge, compare at the next falling edge
  task automatic op(input bit w, input bit r, input int a, input logic [15:0] d, input string req);
    logic [15:0] exp_rd;
    wr_en = w; rd_en = r; addr = a[6:0]; wdata = d;
    exp_rd = r ? 16'(model[a / 2]) : last_rd;
    if (w) model_write(a, d);
    @(negedge clk);
    check({req, " valid"}, {31'd0, rd_valid}, {31'd0, r});
    check({req, " data"}, {16'd0, rdata}, {16'd0, exp_rd});
    last_rd = exp_rd;
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rvalid", {31'd0, rd_valid}, 32'd0);
    check("R1 rdata", {16'd0, rdata}, 32'd0);
    for (int a = 0; a < 128; a += 2) op(0, 1, a, 0, "R1");

    // rule corners, each written then read back
    op(1, 0, 'h10, 16'hA5C3, "R2"); op(0, 1, 'h10, 0, "R2");
    op(1, 0, 'h7C, 16'h1234, "R3"); op(0, 1, 'h7C, 0, "R3");
    op(1, 0, 'h7E, 16'hFFFF, "R3"); op(0, 1, 'h7E, 0, "R3");
    op(1, 0, 'h28, 16'hFFFF, "R4"); op(0, 1, 'h28, 0, "R4");
    op(1, 0, 'h26, 16'hFFFF, "R5"); op(0, 1, 'h26, 0, "R5");
    op(1, 0, 'h26, 16'h0001, "R5"); op(0, 1, 'h26, 0, "R5");
    op(1, 0, 'h2A, 16'hFFFF, "R6"); op(0, 1, 'h2A, 0, "R6");
    op(1, 0, 'h2A, 16'h0000, "R6"); op(0, 1, 'h2A, 0, "R6");
    op(1, 0, 'h32, 16'h0000, "R7"); op(0, 1, 'h32, 0, "R7");
    op(1, 0, 'h34, 16'h1111, "R7"); op(0, 1, 'h35, 0, "R7");
    op(1, 0, 'h0F, 16'h5E5E, "R8"); op(0, 1, 'h0E, 0, "R8");
    op(0, 1, 'h0F, 0, "R8");
    op(0, 0, 0, 0, "R9");
    op(1, 1, 'h40, 16'h7777, "R10"); op(0, 1, 'h40, 0, "R10");
    op(1, 1, 'h26, 16'h8000, "R10"); op(0, 1, 'h26, 0, "R10");

    for (int n = 0; n < 3000; n++) begin
      automatic int a = $urandom_range(0, 127);
      op(1'($urandom), 1'($urandom), a, 16'($urandom), tag_of(a));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule